// File: doc/BRIEF.md
# System Clock Gating Controller

This block decides, cycle by cycle, whether the processor core and the USB device logic receive clock. Both decisions leave the block as synchronous clock-enable signals in the source clock domain. Gated clocks are not generated. Software drives the block through a small register window. One register turns clocks on for each bit written as one. A second register turns clocks off for each bit written as one. A third register reports which clocks are active, and a fourth holds the USB divider code.

Turning the processor clock off puts the core into idle. The request is held until the core signals that its current instruction is complete, and only then does the enable drop. The clock returns without any software action as soon as an enabled normal or fast interrupt is seen. A write of one to the processor bit of the turn-on register also brings it back.

The USB enable is a pulse train taken from the PLL output and divided by 1, 2 or 4. It is only produced while software has enabled it and the PLL reports lock. Idle on the processor side does not affect the USB enable or the register window.

Top module: `sysclk_gate`

## Requirements
- R1: After reset `cpuClkEn` is 1 and `usbClkEn` is 0. The status register (address 2) reads bit 0 = 1 (processor running) and bit 1 = 0 (USB off).
- R2: Writing a word with bit 0 set to the turn-off register (address 1) requests a processor stop. Writing a word with bit 0 set to the turn-on register (address 0) returns the processor clock from a pending stop or from idle one cycle after the write.
- R3: While the processor is stopping or idle, an interrupt line that is both requesting and enabled, or the fast request together with its enable, brings `cpuClkEn` back to 1 one cycle later. A pending stop is cancelled. A request whose enable is low has no effect.
- R4: After a stop request, `cpuClkEn` stays 1 until `instrDone` is seen high in a cycle after the request. It drops to 0 one cycle after that.
- R5: While the processor is idle, register writes and the USB enable keep working.
- R6: Bits [1:0] of the divider register (address 3) choose the USB ratio. Code 0 selects /1, code 1 selects /2, and codes 2 and 3 both select /4. `usbClkEn` is high in the first cycle of each period.
- R7: Bit 1 written as one to address 0 enables the USB clock. Bit 1 written as one to address 1 disables it. Status bit 1 shows whether it is enabled.
- R8: `usbClkEn` is 0 whenever `pllLocked` is 0. Status bit 2 mirrors `pllLocked`.
- R9: Zero bits written to addresses 0 and 1 change nothing. Both addresses read back as 0.
- R10: The divider phase restarts whenever the ratio code changes to a different value or lock is lost. The first cycle after the restart carries a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock (PLL output) |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 turn-on, 1 turn-off, 2 status, 3 divider |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for `regAddr` (combinational) |
| irqReq | input | NUM_IRQ | Normal interrupt requests |
| irqEn | input | NUM_IRQ | Per-line interrupt enables |
| fastIrqReq | input | 1 | Fast interrupt request |
| fastIrqEn | input | 1 | Fast interrupt enable |
| instrDone | input | 1 | Core has completed its current instruction |
| pllLocked | input | 1 | PLL lock indication |
| cpuClkEn | output | 1 | Processor clock enable |
| usbClkEn | output | 1 | USB device clock enable pulse |

## Verification
The divider is run from a table of patterns: every ratio code, one entry with lock low, and a ratio that is selected a second time. Each entry records eight cycles of enable, which distinguishes /1, /2 and /4 and shows that codes 2 and 3 give the same result. Directed sequences then change the ratio and drop lock in the middle of a period, to show that the phase restarts. For the processor clock, the tests separate four paths: a stop that waits on `instrDone`, a wake from a normal line, a wake from the fast request, and a wake from the turn-on register. A masked interrupt and a wake that arrives during a pending stop show that only enabled requests act and that they have priority over completion.

// File: rtl/sysclk_gate_pkg.sv
package sysclk_gate_pkg;
  localparam int REG_ADDR_W = 2;
  localparam int DIV_W      = 2;
  localparam int MAX_SHIFT  = 2;
  localparam int CNT_W      = MAX_SHIFT;

  localparam logic [REG_ADDR_W-1:0] ADDR_SET  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CLR  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_DIV  = 2'd3;

  localparam int BIT_CPU  = 0;
  localparam int BIT_USB  = 1;
  localparam int BIT_LOCK = 2;

  typedef struct packed {
    logic             cpuOn;
    logic             cpuOff;
    logic             usbOn;
    logic             usbOff;
    logic             divWr;
    logic [DIV_W-1:0] divVal;
  } strobe_t;

  typedef enum logic [1:0] {
    CPU_RUN      = 2'd0,
    CPU_STOPPING = 2'd1,
    CPU_IDLE     = 2'd2
  } cpu_state_t;
endpackage

// File: rtl/sysclk_gate_ctrl.sv
module sysclk_gate_ctrl
  import sysclk_gate_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  input  logic [NUM_IRQ-1:0]    irqReq,
  input  logic [NUM_IRQ-1:0]    irqEn,
  input  logic                  fastIrqReq,
  input  logic                  fastIrqEn,
  input  logic                  instrDone,
  output strobe_t               strb,
  output logic                  cpuRun
);
  cpu_state_t stateQ, stateD;
  logic       wake;
  logic       unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:BIT_LOCK];

  // Register decode into one-cycle strobes
  always_comb begin
    strb        = '0;
    strb.cpuOn  = regWr && (regAddr == ADDR_SET) && regWdata[BIT_CPU];
    strb.cpuOff = regWr && (regAddr == ADDR_CLR) && regWdata[BIT_CPU];
    strb.usbOn  = regWr && (regAddr == ADDR_SET) && regWdata[BIT_USB];
    strb.usbOff = regWr && (regAddr == ADDR_CLR) && regWdata[BIT_USB];
    strb.divWr  = regWr && (regAddr == ADDR_DIV);
    strb.divVal = regWdata[DIV_W-1:0];
  end

  assign wake = (|(irqReq & irqEn)) || (fastIrqReq && fastIrqEn);

  // Processor clock state machine
  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      CPU_RUN: begin
        if (strb.cpuOff) stateD = CPU_STOPPING;
      end
      CPU_STOPPING: begin
        if (wake || strb.cpuOn) stateD = CPU_RUN;
        else if (instrDone)     stateD = CPU_IDLE;
      end
      CPU_IDLE: begin
        if (wake || strb.cpuOn) stateD = CPU_RUN;
      end
      default: stateD = CPU_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= CPU_RUN;
    else       stateQ <= stateD;
  end

  assign cpuRun = (stateQ != CPU_IDLE);
endmodule

// File: rtl/sysclk_gate_dp.sv
module sysclk_gate_dp
  import sysclk_gate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic                  cpuRun,
  input  logic                  pllLocked,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0]     regRdata,
  output logic                  usbClkEn,
  output logic                  usbOnQ,
  output logic [DIV_W-1:0]      divSelQ
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntLim;
  logic             ratioChange;

  // Terminal count per ratio code: codes at or above MAX_SHIFT saturate
  always_comb begin
    if (int'(divSelQ) >= MAX_SHIFT) cntLim = CNT_W'((1 << MAX_SHIFT) - 1);
    else                            cntLim = CNT_W'((1 << divSelQ) - 1);
  end

  assign ratioChange = strb.divWr && (strb.divVal != divSelQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usbOnQ  <= 1'b0;
      divSelQ <= '0;
    end else begin
      if (strb.usbOn)       usbOnQ <= 1'b1;
      else if (strb.usbOff) usbOnQ <= 1'b0;
      if (strb.divWr)       divSelQ <= strb.divVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                    cntQ <= '0;
    else if (!pllLocked || !usbOnQ || ratioChange) cntQ <= '0;
    else if (cntQ == cntLim)                      cntQ <= '0;
    else                                          cntQ <= cntQ + 1'b1;
  end

  assign usbClkEn = usbOnQ && pllLocked && (cntQ == '0);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_STAT: begin
        regRdata[BIT_CPU]  = cpuRun;
        regRdata[BIT_USB]  = usbOnQ;
        regRdata[BIT_LOCK] = pllLocked;
      end
      ADDR_DIV: regRdata[DIV_W-1:0] = divSelQ;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/sysclk_gate.sv
module sysclk_gate
  import sysclk_gate_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic [NUM_IRQ-1:0]    irqReq,
  input  logic [NUM_IRQ-1:0]    irqEn,
  input  logic                  fastIrqReq,
  input  logic                  fastIrqEn,
  input  logic                  instrDone,
  input  logic                  pllLocked,
  output logic                  cpuClkEn,
  output logic                  usbClkEn
);
  strobe_t          strb;
  logic             cpuRun;
  logic             usbOnQ;
  logic [DIV_W-1:0] divSelQ;

  sysclk_gate_ctrl #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .irqReq     (irqReq),
    .irqEn      (irqEn),
    .fastIrqReq (fastIrqReq),
    .fastIrqEn  (fastIrqEn),
    .instrDone  (instrDone),
    .strb       (strb),
    .cpuRun     (cpuRun)
  );

  sysclk_gate_dp #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuRun    (cpuRun),
    .pllLocked (pllLocked),
    .regAddr   (regAddr),
    .regRdata  (regRdata),
    .usbClkEn  (usbClkEn),
    .usbOnQ    (usbOnQ),
    .divSelQ   (divSelQ)
  );

  assign cpuClkEn = cpuRun;
endmodule

// File: rtl/sysclk_gate_chk.sv
module sysclk_gate_chk
  import sysclk_gate_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWr,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [NUM_IRQ-1:0]    irqReq,
  input logic [NUM_IRQ-1:0]    irqEn,
  input logic                  fastIrqReq,
  input logic                  fastIrqEn,
  input logic                  instrDone,
  input logic                  pllLocked,
  input logic                  cpuClkEn,
  input logic                  usbClkEn,
  input logic                  usbOnQ,
  input logic [DIV_W-1:0]      divSelQ
);
  logic wakeSeen;
  logic divWrite;
  assign wakeSeen = (|(irqReq & irqEn)) || (fastIrqReq && fastIrqEn);
  assign divWrite = regWr && (regAddr == ADDR_DIV);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !$past(rstN)) |-> (cpuClkEn && !usbClkEn));

  a_r3_irq_wake: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && wakeSeen) |=> cpuClkEn);

  a_r4_stop_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuClkEn) |-> $past(instrDone));

  a_r8_lock_qualifies: assert property (@(posedge clk) disable iff (!rstN)
    usbClkEn |-> pllLocked);

  a_r7_usb_gated: assert property (@(posedge clk) disable iff (!rstN)
    usbClkEn |-> usbOnQ);

  a_r6_half_rate: assert property (@(posedge clk) disable iff (!rstN)
    (usbClkEn && (divSelQ == 2'd1) && !divWrite) |=> !usbClkEn);
endmodule

bind sysclk_gate sysclk_gate_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regWr      (regWr),
  .regAddr    (regAddr),
  .irqReq     (irqReq),
  .irqEn      (irqEn),
  .fastIrqReq (fastIrqReq),
  .fastIrqEn  (fastIrqEn),
  .instrDone  (instrDone),
  .pllLocked  (pllLocked),
  .cpuClkEn   (cpuClkEn),
  .usbClkEn   (usbClkEn),
  .usbOnQ     (usbOnQ),
  .divSelQ    (divSelQ)
);

// File: tb/sysclk_gate_tb_top.sv
module sysclk_gate_tb_top;
  localparam int NUM_IRQ = 8;
  localparam int DATA_W  = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              regWr;
  logic [1:0]        regAddr;
  logic [DATA_W-1:0] regWdata;
  logic [DATA_W-1:0] regRdata;
  logic [NUM_IRQ-1:0] irqReq;
  logic [NUM_IRQ-1:0] irqEn;
  logic              fastIrqReq;
  logic              fastIrqEn;
  logic              instrDone;
  logic              pllLocked;
  logic              cpuClkEn;
  logic              usbClkEn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sysclk_gate #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqReq(irqReq), .irqEn(irqEn),
    .fastIrqReq(fastIrqReq), .fastIrqEn(fastIrqEn), .instrDone(instrDone),
    .pllLocked(pllLocked), .cpuClkEn(cpuClkEn), .usbClkEn(usbClkEn)
  );

  // {divider code, lock, expected usbClkEn over 8 cycles, LSB first}
  localparam logic [10:0] VEC [6] = '{
    {2'd0, 1'b1, 8'hFF},
    {2'd1, 1'b1, 8'h55},
    {2'd2, 1'b1, 8'h11},
    {2'd3, 1'b1, 8'h11},
    {2'd2, 1'b0, 8'h00},
    {2'd1, 1'b1, 8'h55}
  };

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regAddr = a; regWr = 1'b1; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [DATA_W-1:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [DATA_W-1:0] rd;
    logic [7:0]        got;
    rstN = 1'b0; regWr = 1'b0; regAddr = '0; regWdata = '0;
    irqReq = '0; irqEn = '0; fastIrqReq = 1'b0; fastIrqEn = 1'b0;
    instrDone = 1'b1; pllLocked = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 cpuClkEn after reset", cpuClkEn, 1);
    check("R1 usbClkEn after reset", usbClkEn, 0);
    regRead(2'd2, rd);
    check("R1 status after reset", rd, 32'h1);

    // R9: zero writes ignored, set/clear registers read as zero
    pllLocked = 1'b1;
    regRead(2'd0, rd); check("R9 read turn-on reg", rd, 0);
    regRead(2'd1, rd); check("R9 read turn-off reg", rd, 0);
    regWrite(2'd1, 32'h0);
    repeat (2) @(negedge clk);
    #1 check("R9 zero turn-off keeps cpu", cpuClkEn, 1);
    regWrite(2'd0, 32'h0);
    #1 check("R9 zero turn-on keeps usb off", usbClkEn, 0);
    regRead(2'd2, rd); check("R9 status unchanged", rd, 32'h5);

    // R7: enable USB
    regWrite(2'd0, 32'h2);
    regRead(2'd2, rd); check("R7 status usb on", rd, 32'h7);

    // R6/R8: divider table
    foreach (VEC[i]) begin
      pllLocked = 1'b0;
      regWrite(2'd3, {30'd0, VEC[i][10:9]});
      pllLocked = VEC[i][8];
      #1 got[0] = usbClkEn;
      for (int k = 1; k < 8; k++) begin
        @(negedge clk);
        #1 got[k] = usbClkEn;
      end
      check(VEC[i][8] ? "R6 divider pattern" : "R8 no pulse without lock",
            {24'd0, got}, {24'd0, VEC[i][7:0]});
    end
    regRead(2'd3, rd); check("R6 divider readback", rd, 32'h1);

    // R10: ratio change mid-period restarts phase
    regWrite(2'd3, 32'h2);
    #1 check("R10 pulse after change to /4", usbClkEn, 1);
    @(negedge clk); #1 check("R6 /4 second cycle low", usbClkEn, 0);
    regWrite(2'd3, 32'h1);
    #1 check("R10 pulse right after ratio change", usbClkEn, 1);
    @(negedge clk); #1 check("R6 /2 low phase", usbClkEn, 0);
    @(negedge clk); #1 check("R6 /2 high phase", usbClkEn, 1);

    // R10: lock loss restarts phase
    regWrite(2'd3, 32'h2);
    @(negedge clk); #1;
    pllLocked = 1'b0;
    #1 check("R8 lock low forces off", usbClkEn, 0);
    regRead(2'd2, rd); check("R8 status lock bit low", rd, 32'h3);
    @(negedge clk);
    pllLocked = 1'b1;
    #1 check("R10 pulse after relock", usbClkEn, 1);

    // R7: disable USB
    regWrite(2'd1, 32'h2);
    #1 check("R7 usb disabled", usbClkEn, 0);
    regRead(2'd2, rd); check("R7 status usb off", rd, 32'h5);
    regWrite(2'd3, 32'h0);
    #1 check("R7 stays off at /1", usbClkEn, 0);
    regWrite(2'd0, 32'h2);
    #1 check("R7 re-enabled at /1", usbClkEn, 1);

    // R4/R2: deferred stop
    instrDone = 1'b0;
    regWrite(2'd1, 32'h1);
    #1 check("R4 still running while pending", cpuClkEn, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1 check("R4 waits for instrDone", cpuClkEn, 1);
    end
    instrDone = 1'b1;
    @(negedge clk); #1 check("R2 stopped after done", cpuClkEn, 0);
    regRead(2'd2, rd); check("R2 status cpu off", rd, 32'h6);

    // R5: USB and registers live during idle
    check("R5 usb runs in idle", usbClkEn, 1);
    regWrite(2'd3, 32'h1);
    #1 got[0] = usbClkEn;
    @(negedge clk); #1 got[1] = usbClkEn;
    check("R5 divider write in idle", {30'd0, got[1:0]}, 32'h1);
    check("R5 cpu still idle", cpuClkEn, 0);
    regWrite(2'd3, 32'h0);

    // R3: masked interrupt ignored, enabled interrupt wakes
    irqReq = 8'h10;
    repeat (3) @(negedge clk);
    #1 check("R3 masked irq ignored", cpuClkEn, 0);
    irqEn = 8'h10;
    @(negedge clk); #1 check("R3 enabled irq wakes", cpuClkEn, 1);
    irqReq = '0; irqEn = '0;

    // R3: fast interrupt
    regWrite(2'd1, 32'h1);
    @(negedge clk); #1 check("R2 stop again", cpuClkEn, 0);
    fastIrqReq = 1'b1;
    @(negedge clk); #1 check("R3 fast irq masked", cpuClkEn, 0);
    fastIrqEn = 1'b1;
    @(negedge clk); #1 check("R3 fast irq wakes", cpuClkEn, 1);
    fastIrqReq = 1'b0; fastIrqEn = 1'b0;

    // R2: turn-on write wakes from idle
    regWrite(2'd1, 32'h1);
    @(negedge clk); #1 check("R2 idle before turn-on", cpuClkEn, 0);
    regWrite(2'd0, 32'h1);
    #1 check("R2 turn-on write wakes", cpuClkEn, 1);

    // R3: wake during pending stop cancels it
    instrDone = 1'b0;
    regWrite(2'd1, 32'h1);
    fastIrqReq = 1'b1; fastIrqEn = 1'b1;
    @(negedge clk);
    fastIrqReq = 1'b0; fastIrqEn = 1'b0; instrDone = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1 check("R3 pending stop cancelled", cpuClkEn, 1);
    end

    finishRun();
  end
endmodule